// File: doc/BRIEF.md
# GSM TDMA Frame Time Counter

This block keeps the air-interface time of a GSM terminal: an absolute frame number together with the derived counters T1 (superframe index), T2 (26-frame position), T3 (51-frame position) and TC (51-frame block index modulo 8). Every frame strobe moves the time forward by one frame. T2 and T3 step on every advance. TC steps only when the new frame number is a multiple of 51. T1 steps only when the new frame number is a multiple of 1326, the least common multiple of 26 and 51.

A jump request adds an arbitrary frame delta to the current frame number, modulo the hyperframe length of 2,715,648 frames. This is how the time is moved onto a new cell's timebase. After a jump, the four derived counters are recomputed from the new frame number by a two-stage serial divider. A busy flag is raised while this runs, and strobes and further jumps are ignored during that time.

The block presents two times. One is the current time. The other is a registered next time, which always equals the current time advanced by one frame. On each accepted strobe, the current time takes the next time and the next time steps once more.

Top module: `gsm_frame_timer`

## Requirements
- R1: After reset the current time is frame 0 with T1=T2=T3=TC=0. The next time is frame 1 with T2=1, T3=1, T1=0 and TC=0. busy_o is low.
- R2: On a strobe (adv_i high while busy_o is low and jump_i is low), the current time takes the previous next time and the next frame number advances by one. The frame number wraps from 2,715,647 to 0.
- R3: On every single-frame advance, T2 increments modulo 26 and T3 increments modulo 51, so they always equal FN mod 26 and FN mod 51.
- R4: TC increments modulo 8 only when the new frame number is a multiple of 51, so it always equals (FN / 51) mod 8.
- R5: T1 increments modulo 2048 only when the new frame number is a multiple of 1326, so it always equals FN / 1326.
- R6: A jump (jump_i high while busy_o is low) targets (current FN + jump_delta_i) mod 2,715,648. Here jump_delta_i is unsigned and may take any 22-bit value. When busy_o falls, the current time is the target with T1 = FN/1326, T2 = FN mod 26, T3 = FN mod 51 and TC = (FN/51) mod 8, and the next time is the target plus one frame.
- R7: busy_o is high from the edge that accepts a jump until the edge that loads the result, for at most 48 cycles. While it is high, the outputs hold and adv_i and jump_i are ignored.
- R8: When jump_i and adv_i are both high while busy_o is low, the jump is taken and the strobe is dropped.
- R9: With adv_i and jump_i low and busy_o low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Frame strobe: advance one frame |
| jump_i | input | 1 | Jump request |
| jump_delta_i | input | 22 | Frames to add on a jump |
| busy_o | output | 1 | Recompute in progress |
| cur_fn_o | output | 22 | Current frame number |
| cur_t1_o | output | 11 | Current T1 |
| cur_t2_o | output | 5 | Current T2 |
| cur_t3_o | output | 6 | Current T3 |
| cur_tc_o | output | 3 | Current TC |
| nxt_fn_o | output | 22 | Next frame number |
| nxt_t1_o | output | 11 | Next T1 |
| nxt_t2_o | output | 5 | Next T2 |
| nxt_t3_o | output | 6 | Next T3 |
| nxt_tc_o | output | 3 | Next TC |

## Verification
A long run of plain strobes from reset shows whether T2 and T3 wrap independently and whether TC steps only on multiples of 51. Strobes started just before frame 1326 and 2652 separate a correct T1 carry from one that fires on any T2 or T3 wrap. Strobes run just before the hyperframe limit check the wrap of every counter at once. Jumps use small deltas, deltas that cross the hyperframe limit once, and the maximum delta, which needs a double modular reduction; each recomputed result is then stepped forward to catch a next time or counter that is off by one. Strobes and second jumps issued while busy, and a jump issued together with a strobe, show whether the hold-off and the priority rule are met.

// File: rtl/gsm_time_pkg.sv
package gsm_time_pkg;
  localparam int T2_MOD = 26;
  localparam int T3_MOD = 51;
  localparam int T1_MOD = 2048;
  localparam int TC_MOD = 8;
  localparam int SF_LEN = T2_MOD * T3_MOD;
  localparam int HYPER  = SF_LEN * T1_MOD;

  localparam int FN_W = $clog2(HYPER);
  localparam int T1_W = $clog2(T1_MOD);
  localparam int T2_W = $clog2(T2_MOD);
  localparam int T3_W = $clog2(T3_MOD);
  localparam int TC_W = $clog2(TC_MOD);

  localparam logic [FN_W-1:0] FN_MAX = FN_W'(HYPER - 1);
  localparam logic [T1_W-1:0] T1_MAX = T1_W'(T1_MOD - 1);
  localparam logic [T2_W-1:0] T2_MAX = T2_W'(T2_MOD - 1);
  localparam logic [T3_W-1:0] T3_MAX = T3_W'(T3_MOD - 1);
  localparam logic [TC_W-1:0] TC_MAX = TC_W'(TC_MOD - 1);

  typedef struct packed {
    logic [FN_W-1:0] fn;
    logic [T1_W-1:0] t1;
    logic [T2_W-1:0] t2;
    logic [T3_W-1:0] t3;
    logic [TC_W-1:0] tc;
  } gsm_time_t;

  // single-frame advance; carries follow from T2/T3 wrapping together
  function automatic gsm_time_t time_step(input gsm_time_t t);
    gsm_time_t n;
    n    = t;
    n.fn = (t.fn == FN_MAX) ? '0 : t.fn + 1'b1;
    n.t2 = (t.t2 == T2_MAX) ? '0 : t.t2 + 1'b1;
    n.t3 = (t.t3 == T3_MAX) ? '0 : t.t3 + 1'b1;
    if (n.t3 == '0) begin
      n.tc = (t.tc == TC_MAX) ? '0 : t.tc + 1'b1;
      if (n.t2 == '0) n.t1 = (t.t1 == T1_MAX) ? '0 : t.t1 + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/gsm_seq_div.sv
module gsm_seq_div #(
  parameter int DW      = 22,
  parameter int RW      = 6,
  parameter int DIVISOR = 51
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  output logic [DW-1:0] quo_o,
  output logic [RW-1:0] rem_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [RW:0]   DIV_C = (RW+1)'(DIVISOR);
  localparam logic [CW-1:0] CNT_INIT = CW'(DW);

  logic [DW-1:0] quo_q;
  logic [RW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [RW:0]   trial;
  logic          ge;

  // restoring division, one quotient bit per cycle
  assign trial = {rem_q, quo_q[DW-1]};
  assign ge    = (trial >= DIV_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        quo_q <= dividend_i;
        rem_q <= '0;
        cnt_q <= CNT_INIT;
        run_q <= 1'b1;
      end else if (run_q) begin
        quo_q <= {quo_q[DW-2:0], ge};
        rem_q <= ge ? RW'(trial - DIV_C) : trial[RW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;

  // R6
  rem_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < RW'(DIVISOR)));

  // R7
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(run_q));
endmodule

// File: rtl/gsm_time_recompute.sv
module gsm_time_recompute
  import gsm_time_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [FN_W-1:0] fn_i,
  output logic            done_o,
  output gsm_time_t       time_o
);
  logic [FN_W-1:0] q51, q26;
  logic [T3_W-1:0] r51;
  logic [T2_W-1:0] r26;
  logic            done51, done26;
  logic [FN_W-1:0] fn_q;

  // FN = 51*q51 + r51 ; q51 = 26*T1 + r26
  gsm_seq_div #(.DW(FN_W), .RW(T3_W), .DIVISOR(T3_MOD)) div51_i (
    .clk_i, .rst_ni, .start_i, .dividend_i(fn_i),
    .quo_o(q51), .rem_o(r51), .done_o(done51)
  );

  gsm_seq_div #(.DW(FN_W), .RW(T2_W), .DIVISOR(T2_MOD)) div26_i (
    .clk_i, .rst_ni, .start_i(done51), .dividend_i(q51),
    .quo_o(q26), .rem_o(r26), .done_o(done26)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fn_q <= '0;
    else if (start_i) fn_q <= fn_i;
  end

  // 51 = -1 mod 26, so FN mod 26 = (r51 - r26) mod 26
  logic [T3_W:0] t2_s0, t2_s1, t2_s2;
  localparam logic [T3_W:0] T2_C = (T3_W+1)'(T2_MOD);

  always_comb begin
    t2_s0 = (T3_W+1)'(r51) + T2_C - (T3_W+1)'(r26);
    t2_s1 = (t2_s0 >= T2_C) ? t2_s0 - T2_C : t2_s0;
    t2_s2 = (t2_s1 >= T2_C) ? t2_s1 - T2_C : t2_s1;
  end

  assign time_o.fn = fn_q;
  assign time_o.t1 = q26[T1_W-1:0];
  assign time_o.t2 = T2_W'(t2_s2);
  assign time_o.t3 = r51;
  assign time_o.tc = q51[TC_W-1:0];  // TC_MOD is a power of two
  assign done_o    = done26;

  // R5
  t1_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done26 |-> (q26[FN_W-1:T1_W] == '0));
endmodule

// File: rtl/gsm_frame_timer.sv
module gsm_frame_timer
  import gsm_time_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            jump_i,
  input  logic [FN_W-1:0] jump_delta_i,
  output logic            busy_o,
  output logic [FN_W-1:0] cur_fn_o,
  output logic [T1_W-1:0] cur_t1_o,
  output logic [T2_W-1:0] cur_t2_o,
  output logic [T3_W-1:0] cur_t3_o,
  output logic [TC_W-1:0] cur_tc_o,
  output logic [FN_W-1:0] nxt_fn_o,
  output logic [T1_W-1:0] nxt_t1_o,
  output logic [T2_W-1:0] nxt_t2_o,
  output logic [T3_W-1:0] nxt_t3_o,
  output logic [TC_W-1:0] nxt_tc_o
);
  localparam logic [FN_W:0] HYP_C = (FN_W+1)'(HYPER);

  gsm_time_t cur_q, nxt_q, rc_time;
  logic      busy_q, rc_done, take_jump;
  logic [FN_W:0] sum0, sum1, sum2;

  assign take_jump = jump_i && !busy_q;

  // delta may exceed one hyperframe: reduce twice
  always_comb begin
    sum0 = {1'b0, cur_q.fn} + {1'b0, jump_delta_i};
    sum1 = (sum0 >= HYP_C) ? sum0 - HYP_C : sum0;
    sum2 = (sum1 >= HYP_C) ? sum1 - HYP_C : sum1;
  end

  gsm_time_recompute recomp_i (
    .clk_i, .rst_ni,
    .start_i(take_jump),
    .fn_i   (sum2[FN_W-1:0]),
    .done_o (rc_done),
    .time_o (rc_time)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      nxt_q  <= time_step('0);
      busy_q <= 1'b0;
    end else if (take_jump) begin
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (rc_done) begin
        busy_q <= 1'b0;
        cur_q  <= rc_time;
        nxt_q  <= time_step(rc_time);
      end
    end else if (adv_i) begin
      cur_q <= nxt_q;
      nxt_q <= time_step(nxt_q);
    end
  end

  assign busy_o   = busy_q;
  assign cur_fn_o = cur_q.fn;
  assign cur_t1_o = cur_q.t1;
  assign cur_t2_o = cur_q.t2;
  assign cur_t3_o = cur_q.t3;
  assign cur_tc_o = cur_q.tc;
  assign nxt_fn_o = nxt_q.fn;
  assign nxt_t1_o = nxt_q.t1;
  assign nxt_t2_o = nxt_q.t2;
  assign nxt_t3_o = nxt_q.t3;
  assign nxt_tc_o = nxt_q.tc;

  // R2
  next_is_succ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (nxt_q.fn == ((cur_q.fn == FN_MAX) ? '0 : cur_q.fn + 1'b1)));

  // R3
  t2_t3_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.t2 == T2_W'(cur_q.fn % FN_W'(T2_MOD))) &&
    (cur_q.t3 == T3_W'(cur_q.fn % FN_W'(T3_MOD))));

  // R4
  tc_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.tc == TC_W'(cur_q.fn / FN_W'(T3_MOD)));

  // R5
  t1_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.t1 == T1_W'(cur_q.fn / FN_W'(SF_LEN)));

  // R7
  hold_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rc_done) |=> ($stable(cur_q) && $stable(nxt_q) && busy_q));

  // R8
  jump_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && adv_i && !busy_q) |=> (busy_q && $stable(cur_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !adv_i && !jump_i) |=> ($stable(cur_q) && $stable(nxt_q)));
endmodule

// File: tb/gsm_frame_timer_tb_top.sv
`timescale 1ns/1ps
module gsm_frame_timer_tb_top;
  localparam int H = 2715648;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_i = 1'b0, jump_i = 1'b0;
  logic [21:0] jump_delta_i = '0;
  logic        busy_o;
  logic [21:0] cur_fn_o, nxt_fn_o;
  logic [10:0] cur_t1_o, nxt_t1_o;
  logic [4:0]  cur_t2_o, nxt_t2_o;
  logic [5:0]  cur_t3_o, nxt_t3_o;
  logic [2:0]  cur_tc_o, nxt_tc_o;

  always #10 clk_i = ~clk_i;

  gsm_frame_timer dut_i (.*);

  int n_vec = 0, n_bad = 0;
  int m_fn = 0, m_tgt = 0, m_bcnt = 0;
  bit m_pend = 0, m_fresh = 0, last_busy = 0;

  function automatic bit fields_ok(int fn, int afn, int at1, int at2, int at3, int atc);
    return afn == fn && at1 == fn / 1326 && at2 == fn % 26 &&
           at3 == fn % 51 && atc == (fn / 51) % 8;
  endfunction

  task automatic compare(string tag);
    int nf;
    nf = (m_fn + 1) % H;
    n_vec++;
    if (!fields_ok(m_fn, int'(cur_fn_o), int'(cur_t1_o), int'(cur_t2_o),
                   int'(cur_t3_o), int'(cur_tc_o))) begin
      n_bad++;
      $display("FAIL %s cur: fn=%0d t1=%0d t2=%0d t3=%0d tc=%0d exp fn=%0d t1=%0d t2=%0d t3=%0d tc=%0d",
               tag, cur_fn_o, cur_t1_o, cur_t2_o, cur_t3_o, cur_tc_o,
               m_fn, m_fn / 1326, m_fn % 26, m_fn % 51, (m_fn / 51) % 8);
    end
    if (!fields_ok(nf, int'(nxt_fn_o), int'(nxt_t1_o), int'(nxt_t2_o),
                   int'(nxt_t3_o), int'(nxt_tc_o))) begin
      n_bad++;
      $display("FAIL %s nxt: fn=%0d t1=%0d t2=%0d t3=%0d tc=%0d exp fn=%0d t1=%0d t2=%0d t3=%0d tc=%0d",
               tag, nxt_fn_o, nxt_t1_o, nxt_t2_o, nxt_t3_o, nxt_tc_o,
               nf, nf / 1326, nf % 26, nf % 51, (nf / 51) % 8);
    end
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic tick(bit a, bit j, int d, string tag);
    adv_i = a; jump_i = j; jump_delta_i = 22'(d);
    @(posedge clk_i);
    @(negedge clk_i);
    if (!last_busy) begin
      if (j) begin
        m_tgt = (m_fn + d) % H; m_pend = 1; m_fresh = 1; m_bcnt = 0;
      end else if (a) m_fn = (m_fn + 1) % H;
    end
    if (m_pend) begin
      if (busy_o) begin
        m_bcnt++;
        if (m_bcnt > 48) begin
          n_bad++; m_pend = 0;
          $display("FAIL R7 busy too long: act=%0d exp<=48", m_bcnt);
        end
      end else if (m_fresh) begin
        n_bad++; m_pend = 0;
        $display("FAIL R7 busy_o act=0 exp=1 after jump");
      end else begin
        m_fn = m_tgt; m_pend = 0;
      end
      m_fresh = 0;
    end else if (busy_o) begin
      n_bad++;
      $display("FAIL %s busy_o act=1 exp=0", tag);
    end
    n_vec++;
    compare(tag);
    last_busy = busy_o;
  endtask

  task automatic settle(string tag);
    for (int k = 0; k < 60 && m_pend; k++) tick(0, 0, 0, tag);
  endtask

  task automatic jump_to(int fn, string tag);
    tick(0, 1, (fn - m_fn + H) % H, tag);
    settle(tag);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    n_vec++;
    if (busy_o !== 1'b0) begin
      n_bad++; $display("FAIL R1 busy_o act=%0b exp=0", busy_o);
    end
    compare("R1");
    // R2 R3 R4: run from zero across several 51 and 26 boundaries
    for (int k = 0; k < 120; k++) tick(1, 0, 0, "R3_R4");
    // R9 idle hold
    for (int k = 0; k < 5; k++) tick(0, 0, 0, "R9");
    // R6 small jump then step
    jump_to(1320, "R6");
    // R5 cross 1326 and 2652
    for (int k = 0; k < 10; k++) tick(1, 0, 0, "R5");
    jump_to(2648, "R6");
    for (int k = 0; k < 8; k++) tick(1, 0, 0, "R5");
    // R2 hyperframe wrap
    jump_to(H - 4, "R6");
    for (int k = 0; k < 8; k++) tick(1, 0, 0, "R2");
    // R6 max delta needs double reduction
    tick(0, 1, 4194303, "R6");
    settle("R6");
    tick(1, 0, 0, "R6");
    // R6 delta crossing the limit once
    tick(0, 1, 2715000, "R6");
    settle("R6");
    // R7 strobes and a second jump while busy are ignored
    tick(0, 1, 777, "R7");
    for (int k = 0; k < 10; k++) tick(1, 0, 0, "R7");
    tick(0, 1, 5000, "R7");
    for (int k = 0; k < 10; k++) tick(1, 1, 99, "R7");
    settle("R7");
    // R8 jump beats strobe
    tick(1, 1, 51, "R8");
    settle("R8");
    for (int k = 0; k < 60; k++) tick(1, 0, 0, "R4");
    // R6 jump by zero and by one
    tick(0, 1, 0, "R6");
    settle("R6");
    tick(0, 1, 1, "R6");
    settle("R6");
    for (int k = 0; k < 5; k++) tick(0, 0, 0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule